// File: doc/BRIEF.md
# Compare-Match Timer with PWM Output

This block is a 16-bit up-counter with two compare registers and a control register that the host writes and reads over a simple single-cycle register bus. While its run bit is set and the external count enable is high, the counter advances by one on each clock. It can either wrap freely or clear itself after reaching the second compare value. That second mode gives a programmable period.

Each compare register has its own output pin. When the count equals a compare value on an enabled cycle, the two-bit action field for that pin decides whether the pin holds, goes low, goes high or toggles. A PWM bit hands the second pin over to a waveform generator. The pin is active from count 0 up to the first compare value and inactive after it until the counter clears. The same action fields then select the polarity. Codes that are invalid, and fields that disagree with each other, force the pin low.

Register map (word address): 0 control, 1 first compare (CMPA), 2 second compare (CMPB), 3 count (read only).

Top module: `tmr_cmp_pwm`

## Requirements
- R1: After reset the control register, both compare registers and the count read 0, and both pins are 0. The timer is stopped, free-running, with PWM off and both actions set to hold.
- R2: Control readback is bit 14 PWM, bit 13 clear mode, bits 12:11 action B, bits 10:9 action A and bit 0 run. Every other bit, including 31:15, reads 0, and writes to those bits have no effect.
- R3: The count advances by one on a clock only when run (bit 0) and cnt_en are both 1. Otherwise it holds its value.
- R4: With bit 13 = 0 the counter is not cleared by a CMPB match. It wraps from 0xFFFF to 0.
- R5: With bit 13 = 1, on an enabled cycle where the count equals CMPB, the next count is 0. A CMPA match never clears the counter.
- R6: Outside PWM mode, out_b changes on the enabled edge where the count equals CMPB, following action B: 00 hold, 01 drive 0, 10 drive 1, 11 toggle.
- R7: out_a changes on the enabled edge where the count equals CMPA, following action A with the same four encodings.
- R8: A toggle flips its pin once for each match event. While counting is disabled on a matching value, the pin does not change.
- R9: With bit 14 = 1, out_b is a combinational function of the count. With action B = 01 it is 1 while count < CMPA and 0 otherwise. With action B = 10 the levels are inverted.
- R10: With bit 14 = 1, out_b is 0 if action B is 00 or 11, or if action A differs from action B.
- R11: Compare writes take effect on the next cycle. CMPA and CMPB read back zero-extended at addresses 1 and 2. The count reads at address 3, and writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, qualified by the run bit |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for addr, combinational |
| out_a | output | 1 | CMPA compare output pin |
| out_b | output | 1 | CMPB compare output pin or PWM waveform |

## Verification
A register write is captured on the clock edge that ends its wr_en cycle, so readback and any new mode are visible one cycle later. The count and the compare-pin actions update on the same enabled edge in which the match is seen. The PWM level follows the count combinationally, with no added delay. The bench drives each stimulus just after a rising edge and counts the enabled edges up to each match. It places every expected item in the scoreboard so that the monitor compares it at the falling edge of the cycle in which the result is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BIT_PWM  = 14;
  localparam int BIT_TC   = 13;
  localparam int ACTB_LSB = 11;
  localparam int ACTA_LSB = 9;
  localparam int BIT_RUN  = 0;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CMPA = 2'd1;
  localparam logic [1:0] ADR_CMPB = 2'd2;
  localparam logic [1:0] ADR_CNT  = 2'd3;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  typedef struct packed {
    logic       pwm;
    logic       tc;
    logic [1:0] act_b;
    logic [1:0] act_a;
    logic       run;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [31:0] w);
    ctrl_t c;
    c.pwm   = w[BIT_PWM];
    c.tc    = w[BIT_TC];
    c.act_b = w[ACTB_LSB +: 2];
    c.act_a = w[ACTA_LSB +: 2];
    c.run   = w[BIT_RUN];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_encode(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_PWM]       = c.pwm;
    w[BIT_TC]        = c.tc;
    w[ACTB_LSB +: 2] = c.act_b;
    w[ACTA_LSB +: 2] = c.act_a;
    w[BIT_RUN]       = c.run;
    return w;
  endfunction

  function automatic logic pin_next(input logic [1:0] act, input logic cur);
    case (act_e'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic pwm_level(input logic below, input logic [1:0] act_a,
                                     input logic [1:0] act_b);
    logic ok;
    ok = (act_a == act_b) && (act_b == ACT_LOW || act_b == ACT_HIGH);
    if (!ok) return 1'b0;
    return (act_b == ACT_LOW) ? below : ~below;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  input  logic                wr_en,
  input  logic [CW-1:0]       cnt,
  output ctrl_t               ctrl,
  output logic [1:0][CW-1:0]  cmp,
  output logic [DW-1:0]       rdata
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl <= '0;
    else if (wr_en && addr == ADR_CTRL)  ctrl <= ctrl_decode(32'(wdata));
  end

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    localparam logic [1:0] MY_ADR = ADR_CMPA + 2'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cmp[g] <= '0;
      else if (wr_en && addr == MY_ADR)  cmp[g] <= wdata[CW-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADR_CTRL: rdata = DW'(ctrl_encode(ctrl));
      ADR_CMPA: rdata = DW'(cmp[0]);
      ADR_CMPB: rdata = DW'(cmp[1]);
      default:  rdata = DW'(cnt);
    endcase
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr_mode,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic at_limit;
  assign at_limit = clr_mode && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (step)  cnt <= at_limit ? '0 : cnt + ONE;
  end

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       freeze,
  input  logic [1:0] act,
  output logic       pin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pin <= 1'b0;
    else if (hit && !freeze)  pin <= pin_next(act, pin);
  end

endmodule

// File: rtl/tmr_cmp_pwm.sv
module tmr_cmp_pwm
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  output logic [DW-1:0] rdata,
  output logic          out_a,
  output logic          out_b
);

  ctrl_t              ctrl;
  logic [1:0][CW-1:0] cmp;
  logic [CW-1:0]      cnt;
  logic               step;
  logic [1:0]         hit;
  logic [1:0]         pin;
  logic               below_a;

  tmr_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .cnt(cnt), .ctrl(ctrl), .cmp(cmp), .rdata(rdata)
  );

  assign step = ctrl.run && cnt_en;

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clr_mode(ctrl.tc),
    .limit(cmp[1]), .cnt(cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pin
    assign hit[g] = step && (cnt == cmp[g]);
    tmr_pin u_pin (
      .clk(clk), .rst_n(rst_n), .hit(hit[g]),
      .freeze((g == 1) ? ctrl.pwm : 1'b0),
      .act((g == 1) ? ctrl.act_b : ctrl.act_a),
      .pin(pin[g])
    );
  end

  assign below_a = cnt < cmp[0];
  assign out_a   = pin[0];
  assign out_b   = ctrl.pwm ? pwm_level(below_a, ctrl.act_a, ctrl.act_b) : pin[1];

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic [1:0]    addr,
  input logic          wr_en,
  input logic [DW-1:0] rdata,
  input logic          run,
  input logic          tc,
  input logic          pwm,
  input logic [1:0]    act_a,
  input logic [1:0]    act_b,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim,
  input logic          hit_a,
  input logic          hit_b,
  input logic          out_a,
  input logic          out_b
);

  logic [CW-1:0] cnt_up;
  assign cnt_up = cnt + CW'(1);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[DW-1:15] == '0));

  // R3
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cnt_en) |=> $stable(cnt));

  // R4
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && !(tc && cnt == lim)) |=> (cnt == $past(cnt_up)));

  // R5
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && tc && cnt == lim) |=> (cnt == '0));

  // R6
  set_out_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !pwm && act_b == 2'b10 && !wr_en) |=> out_b);

  // R8
  toggle_out_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && act_a == 2'b11) |=> (out_a != $past(out_a)));

  // R10
  pwm_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && (act_b == 2'b00 || act_b == 2'b11)) |-> !out_b);

endmodule

bind tmr_cmp_pwm tmr_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
  .rdata(rdata), .run(ctrl.run), .tc(ctrl.tc), .pwm(ctrl.pwm),
  .act_a(ctrl.act_a), .act_b(ctrl.act_b), .cnt(cnt), .lim(cmp[1]),
  .hit_a(hit[0]), .hit_b(hit[1]), .out_a(out_a), .out_b(out_b)
);

// File: tb/tmr_cmp_pwm_bench.sv
`timescale 1ns/1ps
module tmr_cmp_pwm_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic        out_a, out_b;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string       req;
    int          kind;   // 0 rdata, 1 out_a, 2 out_b
    logic [31:0] exp;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  tmr_cmp_pwm u_tmr_cmp_pwm (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .out_a(out_a), .out_b(out_b)
  );

  // monitor: compares due items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = rdata;
          1:       act = {31'd0, out_a};
          default: act = {31'd0, out_b};
        endcase
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic push(input string req, input int kind, input logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
    @(negedge clk);
    #0.5;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    push(req, 0, exp);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_rd("R1 ctrl", 2'd0, 32'h0);
    chk_rd("R1 cmpa", 2'd1, 32'h0);
    chk_rd("R1 count", 2'd3, 32'h0);
    push("R1 out_a", 1, 0);
    push("R1 out_b", 2, 0);

    // R2 reserved bits and field positions
    wr(2'd0, 32'hFFFF_FFFE);
    chk_rd("R2 readback", 2'd0, 32'h0000_7E00);
    wr(2'd0, 32'h0);

    // R11 compare writes, count read-only
    wr(2'd1, 32'h1234_0005);
    chk_rd("R11 cmpa", 2'd1, 32'h0000_0005);
    wr(2'd2, 32'hABCD_000A);
    chk_rd("R11 cmpb", 2'd2, 32'h0000_000A);
    wr(2'd3, 32'h55);
    chk_rd("R11 count write ignored", 2'd3, 32'h0);

    // R3 counting and gating
    wr(2'd0, 32'h1);
    tick(5);
    chk_rd("R3 count 5", 2'd3, 32'd5);
    cnt_en = 1'b0;
    tick(3);
    chk_rd("R3 hold cnt_en", 2'd3, 32'd5);
    cnt_en = 1'b1;
    wr(2'd0, 32'h0);
    chk_rd("R3 stop", 2'd3, 32'd6);

    // R4 free-running past CMPB, then wrap
    wr(2'd0, 32'h1);
    tick(10);
    chk_rd("R4 no clear", 2'd3, 32'd16);
    tick(65519);
    chk_rd("R4 top", 2'd3, 32'hFFFF);
    tick(1);
    chk_rd("R4 wrap", 2'd3, 32'd0);
    wr(2'd0, 32'h0);

    // R5 clear on CMPB (count now 1)
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h2001);
    tick(9);
    chk_rd("R5 at cmpb", 2'd3, 32'd10);
    tick(1);
    chk_rd("R5 cleared", 2'd3, 32'd0);
    tick(4);
    chk_rd("R5 cmpa no clear", 2'd3, 32'd4);
    wr(2'd0, 32'h2000);

    // R6/R7 actions (count 5): B set, A toggle
    wr(2'd0, 32'h3601);
    tick(5);
    push("R6 before match", 2, 0);
    tick(1);
    push("R6 set", 2, 1);
    tick(4);
    push("R7 toggle on", 1, 1);
    tick(11);
    push("R7 toggle off", 1, 0);
    wr(2'd0, 32'h3600);
    // B clear
    wr(2'd0, 32'h2E01);
    tick(6);
    push("R6 clear", 2, 0);
    // R8 one flip per event
    tick(3);
    push("R8 pre", 1, 0);
    cnt_en = 1'b0;
    tick(5);
    push("R8 no flip while gated", 1, 0);
    cnt_en = 1'b1;
    tick(1);
    push("R8 flip", 1, 1);
    tick(1);
    push("R8 once", 1, 1);
    wr(2'd0, 32'h2E00);
    // R7 hold (count 6)
    wr(2'd0, 32'h2001);
    tick(9);
    push("R7 hold", 1, 1);
    wr(2'd0, 32'h2000);

    // R9 PWM active high (count 5, CMPA 3, CMPB 10)
    wr(2'd0, 32'h6A01);
    push("R9 high inactive", 2, 0);
    tick(6);
    push("R9 high active at 0", 2, 1);
    tick(2);
    push("R9 high active at 2", 2, 1);
    tick(1);
    push("R9 high inactive at 3", 2, 0);
    wr(2'd0, 32'h7401);
    push("R9 low inactive", 2, 1);
    tick(7);
    push("R9 low active", 2, 0);

    // R10 mismatched and invalid codes
    wr(2'd0, 32'h6C01);
    push("R10 mismatch", 2, 0);
    wr(2'd0, 32'h7E01);
    push("R10 code 11", 2, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule